// File: doc/BRIEF.md
# Seven-Level Multicarrier PWM Gate Generator

This block turns a signed digital reference sample stream into gate enables for a seven-level inverter built from six switches. Six triangular carriers are stacked in amplitude bands across the reference range. All six are derived from one shared up/down counter with a programmable peak. The reference is compared against every carrier. The number of carriers it exceeds becomes a signed level from -3 to +3, and that level is decoded into a fixed pattern in which two switches conduct.

Two carrier arrangements are available through a mode input. In alternating-opposition mode, neighbouring bands run in antiphase. In inverted mode, every band falls while the counter rises. A programmable dead time holds all gates off whenever the conducting set changes. An enable input shuts the stage down and restarts the carrier. The block also reports the current level and raises a flag if more than two gates would ever be on together.

Top module: `mlp7_gate_gen`

## Requirements
- R1: With peak value P (`period_i`, where 0 is treated as 1), the carrier counter runs 0,1,...,P,P-1,...,1,0,1,... so that one carrier period lasts 2P clocks. It starts at 0 counting up after reset or while disabled.
- R2: The reference r is compared as u = r + 3P against six carriers c_k = k·P + t_k for k = 0..5, where t_k is the counter value for a rising band and P minus the counter for a falling band. With `mode_i`=0, bands 1, 3 and 5 fall and bands 0, 2 and 4 rise. With `mode_i`=1, all six bands fall.
- R3: `level_o` equals the number of carriers with u > c_k minus 3. It is registered, so it reflects the counter and held reference of the previous clock.
- R4: `level_o` is a 3-bit two's complement value that stays within -3..+3.
- R5: Bit i of `gate_o` drives switch i+1. The decode is: +1 gives 6'b100010, +2 gives 6'b100001, +3 gives 6'b100100, 0 gives 6'b000000, -1 gives 6'b001001, -2 gives 6'b001010, -3 gives 6'b011000.
- R6: When any gate is on, exactly two gates are on, and bit 5 (positive polarity) and bit 3 (negative polarity) are never on together.
- R7: The reference is captured only on the clock that ends a peak cycle, which is a cycle where the counter is rising and has reached P. The held sample is cleared by reset and by disable.
- R8: When the decoded set differs from the last one seen, `gate_o` goes to all-off on the next edge. It stays off for `dead_i`+1 clocks in total, then drives the new set. A further change restarts the interval.
- R9: While `en_i` is low, all gates are off from the next clock edge, and the counter, held reference and level are cleared.
- R10: `overlap_o` is high exactly when more than two bits of `gate_o` are set. This never happens in correct operation.
- R11: During reset, `gate_o`, `level_o` and `overlap_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low forces all gates off |
| mode_i | input | 1 | 0 alternating-opposition bands, 1 all bands inverted |
| period_i | input | CNT_W | Carrier counter peak P |
| dead_i | input | DT_W | Extra all-off clocks on a set change |
| ref_i | input | REF_W | Signed reference sample |
| gate_o | output | 6 | Gate enables, bit i for switch i+1 |
| level_o | output | 3 | Current signed level |
| overlap_o | output | 1 | More than two gates on |

## Verification
The bench builds the block with REF_W=8, CNT_W=4 and DT_W=3. This keeps every carrier period short enough to sweep completely. It sweeps the peaks 1, 3 and 4, dead times 0 and 2, and both carrier modes, with every reference value from one step below the bottom band to one step above the top band. These sizes put every band crossing and all seven levels within reach, along with every switch-set change and its dead interval, saturation at both ends, enable drops in the middle of a period, and the zero-peak substitution. A cycle-by-cycle arithmetic model of the requirements supplies the expected gates and level on every clock.

// File: rtl/mlp7_pkg.sv
package mlp7_pkg;
  localparam int unsigned NUM_SW   = 6;
  localparam int unsigned NUM_BAND = 6;

  typedef logic signed [2:0] level_t;
  typedef logic [NUM_SW-1:0] gate_t;

  // bit i drives switch i+1; bit 5 positive polarity, bit 3 negative polarity
  function automatic gate_t level_to_gates(level_t lv);
    gate_t g;
    case (lv)
      3'b001:  g = 6'b100010;
      3'b010:  g = 6'b100001;
      3'b011:  g = 6'b100100;
      3'b111:  g = 6'b001001;
      3'b110:  g = 6'b001010;
      3'b101:  g = 6'b011000;
      default: g = 6'b000000;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/mlp7_carrier_cnt.sv
module mlp7_carrier_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             peak_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q >= per_i) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (cnt_q == '0) begin
      up_q  <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign peak_o = up_q && (cnt_q >= per_i);
endmodule

// File: rtl/mlp7_band_cmp.sv
module mlp7_band_cmp
  import mlp7_pkg::*;
#(
  parameter int unsigned REF_W = 16,
  parameter int unsigned CNT_W = 12
) (
  input  logic signed [REF_W-1:0] ref_i,
  input  logic        [CNT_W-1:0] cnt_i,
  input  logic        [CNT_W-1:0] per_i,
  input  logic                    mode_i,
  output level_t                  level_o
);
  localparam int unsigned CW = ((REF_W > CNT_W + 3) ? REF_W : CNT_W + 3) + 2;

  logic signed [CW-1:0] ref_s, per_s, cnt_s, ref_u;
  logic [NUM_BAND-1:0]  hit;
  logic [2:0]           n_hit;
  logic signed [3:0]    lv4;

  assign ref_s = CW'(ref_i);
  assign per_s = $signed(CW'(per_i));
  assign cnt_s = $signed(CW'(cnt_i));
  assign ref_u = ref_s + per_s + per_s + per_s;

  for (genvar k = 0; k < NUM_BAND; k++) begin : g_band
    localparam logic signed [CW-1:0] KS  = CW'(k);
    localparam bit                   ODD = (k % 2) == 1;
    logic                 inv;
    logic signed [CW-1:0] ofs, car;
    assign inv    = mode_i | ODD;
    assign ofs    = inv ? (per_s - cnt_s) : cnt_s;
    assign car    = per_s * KS + ofs;
    assign hit[k] = ref_u > car;
  end

  always_comb begin
    n_hit = '0;
    for (int i = 0; i < NUM_BAND; i++) n_hit = n_hit + {2'b00, hit[i]};
  end

  assign lv4     = $signed({1'b0, n_hit}) - 4'sd3;
  assign level_o = lv4[2:0];
endmodule

// File: rtl/mlp7_gate_seq.sv
module mlp7_gate_seq
  import mlp7_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  gate_t           target_i,
  input  logic [DT_W-1:0] dead_i,
  output gate_t           gate_o,
  output logic            overlap_o
);
  gate_t           gate_q, last_q;
  logic [DT_W-1:0] dt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      last_q <= '0;
      dt_q   <= '0;
    end else if (!en_i) begin
      gate_q <= '0;
      last_q <= '0;
      dt_q   <= '0;
    end else if (target_i != last_q) begin
      gate_q <= '0;
      last_q <= target_i;
      dt_q   <= dead_i;
    end else if (dt_q != '0) begin
      gate_q <= '0;
      dt_q   <= dt_q - 1'b1;
    end else begin
      gate_q <= last_q;
    end
  end

  assign gate_o    = gate_q;
  assign overlap_o = $countones(gate_q) > 2;
endmodule

// File: rtl/mlp7_gate_gen.sv
module mlp7_gate_gen
  import mlp7_pkg::*;
#(
  parameter int unsigned REF_W = 16,
  parameter int unsigned CNT_W = 12,
  parameter int unsigned DT_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    mode_i,
  input  logic        [CNT_W-1:0] period_i,
  input  logic        [DT_W-1:0]  dead_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic        [5:0]       gate_o,
  output logic signed [2:0]       level_o,
  output logic                    overlap_o
);
  logic        [CNT_W-1:0] per_eff, cnt;
  logic                    peak;
  logic signed [REF_W-1:0] ref_q;
  level_t                  lvl_c, lvl_q;
  gate_t                   target;

  assign per_eff = (period_i == '0) ? CNT_W'(1) : period_i;

  mlp7_carrier_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .per_i (per_eff),
    .cnt_o (cnt),
    .peak_o(peak)
  );

  // reference held for a whole carrier period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ref_q <= '0;
    else if (!en_i) ref_q <= '0;
    else if (peak)  ref_q <= ref_i;
  end

  mlp7_band_cmp #(.REF_W(REF_W), .CNT_W(CNT_W)) u_cmp (
    .ref_i  (ref_q),
    .cnt_i  (cnt),
    .per_i  (per_eff),
    .mode_i (mode_i),
    .level_o(lvl_c)
  );

  assign target = level_to_gates(lvl_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lvl_q <= '0;
    else if (!en_i) lvl_q <= '0;
    else            lvl_q <= lvl_c;
  end
  assign level_o = lvl_q;

  mlp7_gate_seq #(.DT_W(DT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .target_i (target),
    .dead_i   (dead_i),
    .gate_o   (gate_o),
    .overlap_o(overlap_o)
  );
endmodule

// File: rtl/mlp7_gate_gen_chk.sv
module mlp7_gate_gen_chk (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic        [5:0] gate_o,
  input logic signed [2:0] level_o,
  input logic              overlap_o
);
  AST_TWO_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o != 6'd0) |-> ($countones(gate_o) == 2)); // R6

  AST_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o[5] |-> !gate_o[3]); // R6

  AST_BREAK_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gate_o != 6'd0) && ($past(gate_o) != 6'd0)) |-> (gate_o == $past(gate_o))); // R8

  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (gate_o == 6'd0)); // R9

  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o != 3'b100); // R4

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !overlap_o); // R10
endmodule

bind mlp7_gate_gen mlp7_gate_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .gate_o   (gate_o),
  .level_o  (level_o),
  .overlap_o(overlap_o)
);

// File: tb/sim_mlp7_gate_gen.sv
`timescale 1ns/1ps
module sim_mlp7_gate_gen;
  localparam int REF_W = 8;
  localparam int CNT_W = 4;
  localparam int DT_W  = 3;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    en = 1'b0;
  logic                    mode = 1'b0;
  logic        [CNT_W-1:0] period = 4'd1;
  logic        [DT_W-1:0]  dead = '0;
  logic signed [REF_W-1:0] ref_s = '0;
  logic        [5:0]       gate;
  logic signed [2:0]       level;
  logic                    ovl;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mlp7_gate_gen #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .period_i(period), .dead_i(dead), .ref_i(ref_s),
    .gate_o(gate), .level_o(level), .overlap_o(ovl)
  );

  // expected switch pattern per level (R5)
  function automatic logic [5:0] tbl(int lv);
    case (lv)
      1:  return 6'b100010;
      2:  return 6'b100001;
      3:  return 6'b100100;
      -1: return 6'b001001;
      -2: return 6'b001010;
      -3: return 6'b011000;
      default: return 6'b000000;
    endcase
  endfunction

  int         m_cnt, m_up, m_ref, m_dt, m_lvl;
  logic [5:0] m_last, m_gate;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      m_cnt = 0; m_up = 1; m_ref = 0; m_dt = 0; m_lvl = 0;
      m_last = '0; m_gate = '0;
    end else begin
      int p, n, lv;
      logic [5:0] tgt;
      p = (period == 0) ? 1 : int'(period);
      n = 0;
      for (int k = 0; k < 6; k++) begin
        int car;
        car = k * p + ((mode || (k % 2 == 1)) ? (p - m_cnt) : m_cnt);
        if (m_ref + 3 * p > car) n++;
      end
      lv  = n - 3;
      tgt = tbl(lv);
      if (tgt != m_last) begin
        m_gate = '0; m_last = tgt; m_dt = int'(dead);
      end else if (m_dt != 0) begin
        m_dt--; m_gate = '0;
      end else begin
        m_gate = m_last;
      end
      m_lvl = lv;
      if (m_up == 1 && m_cnt >= p) m_ref = int'(ref_s);
      if (m_up == 1) begin
        if (m_cnt >= p) begin m_up = 0; m_cnt--; end
        else m_cnt++;
      end else if (m_cnt == 0) begin
        m_up = 1; m_cnt++;
      end else begin
        m_cnt--;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(gate == m_gate, "R5 R8 gate pattern", int'(gate), int'(m_gate));
    chk(int'(level) == m_lvl, "R1 R2 R3 R7 level", int'(level), m_lvl);
    chk(level != 3'b100, "R4 level range", int'(level), 0);
    chk(gate == 0 || ($countones(gate) == 2 && !(gate[5] && gate[3])),
        "R6 two on, one polarity", int'(gate), int'(m_gate));
    chk(ovl == 1'b0, "R10 overlap flag", int'(ovl), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pv[3] = '{1, 3, 4};
    repeat (3) @(negedge clk);
    chk(gate == 0, "R11 reset gates", int'(gate), 0);
    chk(level == 0, "R11 reset level", int'(level), 0);
    chk(ovl == 0, "R11 reset overlap", int'(ovl), 0);
    rst_n = 1'b1;
    en    = 1'b1;
    for (int md = 0; md < 2; md++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int dv = 0; dv <= 2; dv += 2) begin
          mode   = md[0];
          period = CNT_W'(pv[pi]);
          dead   = DT_W'(dv);
          for (int r = -3 * pv[pi] - 1; r <= 3 * pv[pi] + 1; r++) begin
            ref_s = REF_W'(r);
            repeat (4 * pv[pi] + 4) tick();
          end
          // R9: drop enable mid-run
          ref_s = REF_W'(2 * pv[pi]);
          repeat (5) tick();
          en = 1'b0;
          tick();
          chk(gate == 0, "R9 disabled gates", int'(gate), 0);
          chk(level == 0, "R9 disabled level", int'(level), 0);
          tick();
          en = 1'b1;
        end
      end
    end
    // R1: zero peak behaves as peak 1
    period = '0;
    dead   = '0;
    for (int r = -4; r <= 4; r++) begin
      ref_s = REF_W'(r);
      repeat (8) tick();
    end
    // saturation at both ends with a larger peak
    period = 4'd7;
    ref_s  = 8'sd30;
    repeat (40) tick();
    chk(int'(level) == 3, "R3 top saturation", int'(level), 3);
    ref_s  = -8'sd30;
    repeat (40) tick();
    chk(int'(level) == -3, "R3 bottom saturation", int'(level), -3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule